// File: doc/BRIEF.md
# Protected Watchdog Timer

This block is the watchdog of an 8051-style core. Once enabled, it counts machine cycles. Each machine cycle is a fixed number of oscillator clocks, produced by a small prescaler. If software lets the count run for the full timeout, the block issues a one-clock request to the reset controller. That controller asserts the internal reset and records that the watchdog caused it.

Software reaches the block through two register write strobes. Both share one data byte:

- A write to the power-control register updates the enable bit.
- A write to the interrupt-priority register with its restart bit set clears the count.

Both writes take effect only while the timed-access logic reports an open window. Any other write leaves the block untouched. The unlock sequence and the reset controller sit outside this block.

The default configuration is 12 oscillator clocks per machine cycle and a timeout of 122,880 machine cycles. At 12 MHz that is 122.88 ms.

Top module: `prot_wdog`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wdt_en` and `wdt_req` are both 0.
- R2: A power-control write made while `ta_ok` is 0 leaves `wdt_en` unchanged, whatever the data byte.
- R3: A power-control write made while `ta_ok` is 1 loads `wdata[2]` into `wdt_en`, visible on the next cycle. A 1 enables the timer.
- R4: When `wdt_en` rises at clock edge k and no restart or reset follows, `wdt_req` is high in the cycle after edge k + CLKS_PER_MC*TIMEOUT_MC.
- R5: `wdt_req` is high for one clock per expiry. It does not rise again until the count has been cleared.
- R6: An interrupt-priority write with `wdata[7]` = 1 while `ta_ok` is 1 clears both the prescaler and the count. The next request comes CLKS_PER_MC*TIMEOUT_MC edges after that write's edge.
- R7: An interrupt-priority write made without `ta_ok`, or with `wdata[7]` = 0, neither restarts the count nor changes `wdt_en`.
- R8: While `wdt_en` is 0, the count is held at zero, restarts have no effect, and `wdt_req` stays 0.
- R9: A system reset clears the enable, prescaler and count. After re-enabling, the full timeout applies again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous system reset, active high |
| ta_ok | input | 1 | Timed-access window is open |
| pcon_we | input | 1 | Write strobe of the power-control register |
| ip_we | input | 1 | Write strobe of the interrupt-priority register |
| wdata | input | DW | Write data byte (bit 2 = enable, bit 7 = restart) |
| wdt_req | output | 1 | One-clock watchdog reset request |
| wdt_en | output | 1 | Current enable state |

## Verification
Every write lands on one clock edge. `wdt_en` changes in the cycle after that edge. `wdt_req` is registered, so it is due exactly CLKS_PER_MC*TIMEOUT_MC edges after the enabling or restarting edge, with no further latency.

The bench drives inputs and samples outputs on falling edges. It numbers each falling edge from the write that started the window and records the index of the first request and the number of request cycles. It then compares these with the window length computed from the parameters. Ignored writes are placed inside a running window, and their effect shows up as an unshifted expiry index.

// File: rtl/prot_wdog.sv
`timescale 1ns/1ps
module prot_wdog #(
  parameter int CLKS_PER_MC = 12,
  parameter int TIMEOUT_MC  = 122880,
  parameter int DW          = 8,
  parameter int EN_BIT      = 2,
  parameter int RS_BIT      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ta_ok,
  input  logic          pcon_we,
  input  logic          ip_we,
  input  logic [DW-1:0] wdata,
  output logic          wdt_req,
  output logic          wdt_en
);
  localparam int PW = (CLKS_PER_MC > 1) ? $clog2(CLKS_PER_MC) : 1;
  localparam int CW = $clog2(TIMEOUT_MC + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_MC - 1);
  localparam logic [CW-1:0] CNT_TOP  = CW'(TIMEOUT_MC);
  localparam logic [CW-1:0] CNT_NEAR = CW'(TIMEOUT_MC - 1);

  logic [PW-1:0] pre;
  logic [CW-1:0] mcnt;

  wire en_take = ta_ok & pcon_we;
  wire kick    = ta_ok & ip_we & wdata[RS_BIT];
  wire clr     = rst | ~wdt_en | kick;
  wire mc_tick = (pre == PRE_LAST);
  wire expired = (mcnt == CNT_TOP);
  wire unused_data = &{1'b0, wdata};

  always_ff @(posedge clk)
    if (rst)          wdt_en <= 1'b0;
    else if (en_take) wdt_en <= wdata[EN_BIT];

  always_ff @(posedge clk)
    if (clr || mc_tick) pre <= '0;
    else                pre <= pre + PW'(1);

  always_ff @(posedge clk)
    if (clr)                      mcnt <= '0;
    else if (mc_tick && !expired) mcnt <= mcnt + CW'(1);

  always_ff @(posedge clk)
    if (clr) wdt_req <= 1'b0;
    else     wdt_req <= mc_tick && (mcnt == CNT_NEAR);
endmodule

// File: rtl/prot_wdog_props.sv
`timescale 1ns/1ps
module prot_wdog_props #(
  parameter int CLKS_PER_MC = 12,
  parameter int TIMEOUT_MC  = 122880,
  parameter int DW          = 8,
  parameter int EN_BIT      = 2,
  parameter int RS_BIT      = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ta_ok,
  input logic          pcon_we,
  input logic          ip_we,
  input logic [DW-1:0] wdata,
  input logic          wdt_req,
  input logic          wdt_en
);
  localparam int WIN = CLKS_PER_MC * TIMEOUT_MC;
  localparam int SW  = $clog2(WIN + 2);
  localparam logic [SW-1:0] SAT = SW'(WIN + 1);

  logic [SW-1:0] since;
  wire kick = ta_ok & ip_we & wdata[RS_BIT];
  wire unused_data = &{1'b0, wdata};

  always_ff @(posedge clk)
    if (rst || !wdt_en || kick) since <= '0;
    else if (since != SAT)      since <= since + SW'(1);

  assert_en_locked_R2: assert property (@(posedge clk) disable iff (rst)
    !(ta_ok && pcon_we) |=> $stable(wdt_en));
  assert_en_load_R3: assert property (@(posedge clk) disable iff (rst)
    (ta_ok && pcon_we) |=> (wdt_en == $past(wdata[EN_BIT])));
  assert_req_window_R4: assert property (@(posedge clk) disable iff (rst)
    wdt_req |-> (since == SW'(WIN)));
  assert_req_due_R4: assert property (@(posedge clk) disable iff (rst)
    (since == SW'(WIN - 1) && wdt_en && !kick) |=> wdt_req);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    wdt_req |=> !wdt_req);
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !wdt_en |=> !wdt_req);
endmodule

bind prot_wdog prot_wdog_props #(
  .CLKS_PER_MC(CLKS_PER_MC), .TIMEOUT_MC(TIMEOUT_MC),
  .DW(DW), .EN_BIT(EN_BIT), .RS_BIT(RS_BIT)
) u_props (
  .clk(clk), .rst(rst), .ta_ok(ta_ok), .pcon_we(pcon_we), .ip_we(ip_we),
  .wdata(wdata), .wdt_req(wdt_req), .wdt_en(wdt_en)
);

// File: tb/test_prot_wdog.sv
`timescale 1ns/1ps
module test_prot_wdog;
  localparam int C = 3;
  localparam int T = 4;
  localparam int N = C * T;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ta_ok = 1'b0, pcon_we = 1'b0, ip_we = 1'b0;
  logic [7:0] wdata = '0;
  logic wdt_req, wdt_en;
  int tests = 0, fails = 0;
  int first, cnt;

  always #4 clk = ~clk;

  prot_wdog #(.CLKS_PER_MC(C), .TIMEOUT_MC(T)) i_prot_wdog (
    .clk(clk), .rst(rst), .ta_ok(ta_ok), .pcon_we(pcon_we), .ip_we(ip_we),
    .wdata(wdata), .wdt_req(wdt_req), .wdt_en(wdt_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input bit to_pcon, input logic [7:0] d, input bit ta);
    pcon_we = to_pcon; ip_we = !to_pcon; wdata = d; ta_ok = ta;
    @(negedge clk);
    pcon_we = 0; ip_we = 0; ta_ok = 0; wdata = '0;
  endtask

  task automatic run(input int n, output int f, output int c);
    f = 0; c = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (wdt_req) begin
        c++;
        if (f == 0) f = i;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wdt_en && !wdt_req, "R1 during reset", int'(wdt_en), 0);
    rst = 0;
    @(negedge clk);
    chk(!wdt_en && !wdt_req, "R1 after reset", int'(wdt_en), 0);

    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v), 0);
      chk(wdt_en == 1'b0, "R2 locked enable", int'(wdt_en), 0);
    end
    for (int v = 0; v < 256; v++) begin
      wr(1, 8'(v), 1);
      chk(wdt_en == v[2], "R3 enable bit 2", int'(wdt_en), int'(v[2]));
    end
    wr(1, 8'h00, 1);
    chk(wdt_en == 1'b0, "R3 disable", int'(wdt_en), 0);

    wr(1, 8'h04, 1);
    run(3 * N, first, cnt);
    chk(first == N, "R4 expiry cycle", first, N);
    chk(cnt == 1, "R5 single pulse", cnt, 1);

    wr(0, 8'h80, 1);
    run(7, first, cnt);
    chk(cnt == 0, "R6 no early pulse", cnt, 0);
    wr(0, 8'h80, 1);
    run(2 * N, first, cnt);
    chk(first == N, "R6 restart window", first, N);
    chk(cnt == 1, "R6 one pulse", cnt, 1);

    wr(0, 8'h80, 1);
    run(5, first, cnt);
    chk(cnt == 0, "R7 no early pulse", cnt, 0);
    wr(0, 8'hFF, 0);
    wr(0, 8'h7F, 1);
    chk(wdt_en == 1'b1, "R7 enable untouched", int'(wdt_en), 1);
    run(2 * N, first, cnt);
    chk(first == N - 7, "R7 window not shifted", first, N - 7);
    chk(cnt == 1, "R7 one pulse", cnt, 1);

    wr(1, 8'h00, 1);
    run(3 * N, first, cnt);
    chk(cnt == 0, "R8 disabled quiet", cnt, 0);
    wr(0, 8'h80, 1);
    run(3 * N, first, cnt);
    chk(cnt == 0, "R8 restart while off", cnt, 0);
    chk(wdt_en == 1'b0, "R8 stays off", int'(wdt_en), 0);

    wr(1, 8'h04, 1);
    run(5, first, cnt);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk(wdt_en == 1'b0, "R9 reset clears enable", int'(wdt_en), 0);
    run(3 * N, first, cnt);
    chk(cnt == 0, "R9 quiet after reset", cnt, 0);
    wr(1, 8'h04, 1);
    run(2 * N, first, cnt);
    chk(first == N, "R9 full window after reset", first, N);
    chk(cnt == 1, "R9 one pulse", cnt, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule